// File: doc/BRIEF.md
# Cascadable Serial Control Word Decoder

This block sits on a serial control port that several identical devices share in a daisy chain. It receives 16-bit control words on a serial input, MSB first. Each word is framed by an input frame sync that is high for one serial clock period just before the first bit. Bit 15 marks a control word, and bit 14 chooses read or write. Bits 13 to 11 carry a device address, bits 10 to 8 select a register, and bits 7 to 0 carry data. A word is acted on locally only when its device address is zero. Any other control word is handed downstream with its device address lowered by one.

A local write stores the data byte in one of five 8-bit control registers. A local read sends the word back out with its data byte replaced by the register contents. Forwarded words and readback words share one serial output. They leave during the next output frame, and an output frame sync precedes each one. The block divides the master clock to make the serial clock and the frame timing. Register 0 holds the mode bit (bit 0) and a self-clearing reset bit (bit 7).

Top module: `ctlw_chain`

## Requirements
- R1: On a serial clock tick with `sdi_fs` high, the receiver arms. The next 16 ticks shift in `sdi` MSB first to form one word.
- R2: A word with bit 15 low changes no register and produces no output word, whether `data_mode` is 0 or 1.
- R3: A control word whose bits 13..11 are nonzero is sent out in the next output frame. Its bits 13..11 are lowered by one, and every other bit is unchanged. No register changes.
- R4: A control word with device address 0 and bit 14 low writes bits 7..0 into register bits 10..8, for registers 0 to 4. The stored values appear on `ctl_regs` at bits [8*i+7 : 8*i].
- R5: A control word with device address 0 and bit 14 high is sent out in the next output frame. Its bits 7..0 are replaced by the selected register, and bits 15..8 are unchanged.
- R6: Register selects 5 to 7 are reserved. Writes to them change nothing, and reads return a data byte of 0.
- R7: While `rst_n` is low, and after it is released, every register is 0x00.
- R8: A write to register 0 with bit 7 set stores none of its bits. It clears all registers, and they stay clear for RST_CYCLES master clocks.
- R9: `sdo_fs` first goes high 280 master clocks after reset is released, then again every FRAME_DIV master clocks. It stays high for one serial clock period, and the 16 output bits follow MSB first.
- R10: An output frame with no pending word carries all zeros.
- R11: `data_mode` follows register 0 bit 0 and is 0 after either reset.
- R12: Register 0 bit 7 always reads back as 0.
- R13: `sclk` has a period of SCLK_DIV master clocks. It is low in the first half of each period and high in the second half. Inputs are sampled and outputs change at its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sdi | input | 1 | Serial control word input |
| sdi_fs | input | 1 | Input frame sync, one serial clock before the MSB |
| sclk | output | 1 | Serial clock, master clock divided by SCLK_DIV |
| sdo | output | 1 | Serial output for forwarded and readback words |
| sdo_fs | output | 1 | Output frame sync, one serial clock before the MSB |
| data_mode | output | 1 | Register 0 bit 0: 0 program mode, 1 data/mixed mode |
| ctl_regs | output | 8*NUM_REGS | Register contents, register i at bits [8*i+7:8*i] |

## Verification
The bench sweeps every device address with both read and write words. A decrement applied at the wrong bit, or applied to local words, would corrupt the forwarded copy. It writes and reads all eight register selects with several patterns. A decoder that aliases selects 5 to 7 onto real registers would either overwrite them or read them back instead of zero. It sends words with bit 15 low in both modes, which catches a design that lets them write or forward. It also measures the first output frame sync, which exposes a frame counter that is off by one, and checks that the self-reset write clears everything and leaves bit 7 reading zero.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  typedef struct packed {
    logic       ctl;
    logic       rd;
    logic [2:0] dev;
    logic [2:0] sel;
    logic [7:0] data;
  } ctlw_word_t;

  localparam int WORD_BITS = $bits(ctlw_word_t);
  localparam int SEL_BITS  = 3;
endpackage

// File: rtl/ctlw_timing.sv
module ctlw_timing #(
  parameter int SCLK_DIV  = 8,
  parameter int FRAME_DIV = 2048,
  parameter int FIRST_FS  = 280
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic frame_evt,
  output logic sclk
);
  localparam int DIV_W  = $clog2(SCLK_DIV);
  localparam int FC_MAX = (FIRST_FS > FRAME_DIV) ? FIRST_FS : FRAME_DIV;
  localparam int FC_W   = $clog2(FC_MAX + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [FC_W-1:0]  fcnt_q, fcnt_d;

  always_comb begin
    tick      = (div_q == DIV_W'(SCLK_DIV - 1));
    div_d     = tick ? '0 : div_q + 1'b1;
    frame_evt = (fcnt_q == '0);
    fcnt_d    = frame_evt ? FC_W'(FRAME_DIV - 1) : fcnt_q - 1'b1;
    sclk      = (div_q >= DIV_W'(SCLK_DIV / 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      fcnt_q <= FC_W'(FIRST_FS - 1);
    end else begin
      div_q  <= div_d;
      fcnt_q <= fcnt_d;
    end
  end

  // R9: output frames start only on a serial clock boundary
  p_frame_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |-> tick);
endmodule

// File: rtl/ctlw_rx.sv
module ctlw_rx
  import ctlw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sdi,
  input  logic       sdi_fs,
  output logic       word_vld,
  output ctlw_word_t word
);
  logic                 armed_q, armed_d;
  logic [3:0]           cnt_q, cnt_d;
  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic                 vld_q, vld_d;
  logic [WORD_BITS-1:0] word_q, word_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    vld_d   = 1'b0;
    word_d  = word_q;
    if (tick) begin
      if (sdi_fs) begin
        armed_d = 1'b1;
        cnt_d   = '0;
      end else if (armed_q) begin
        sh_d  = {sh_q[WORD_BITS-2:0], sdi};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == 4'd15) begin
          vld_d   = 1'b1;
          word_d  = {sh_q[WORD_BITS-2:0], sdi};
          armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      vld_q   <= vld_d;
      word_q  <= word_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = ctlw_word_t'(word_q);

  // R1: a completed word is reported for a single master clock
  p_word_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/ctlw_regfile.sv
module ctlw_regfile #(
  parameter int NUM_REGS   = 5,
  parameter int RST_CYCLES = 4,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [7:0]            wr_data,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]           clr_q, clr_d;
  logic [NUM_REGS-1:0][7:0]   regs_q, regs_d;
  logic                       clearing;
  logic                       soft_go;

  always_comb begin
    clearing = (clr_q != '0);
    soft_go  = wr_en && !clearing && (wr_sel == '0) && wr_data[7];
    if (soft_go)       clr_d = CNT_W'(RST_CYCLES);
    else if (clearing) clr_d = clr_q - 1'b1;
    else               clr_d = clr_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (clearing)
        regs_d[i] = 8'h00;
      else if (wr_en && !soft_go && (wr_sel == SEL_W'(i)))
        regs_d[i] = wr_data;
      else
        regs_d[i] = regs_q[i];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel == SEL_W'(i)) rd_data = regs_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= CNT_W'(RST_CYCLES);
      regs_q <= '0;
    end else begin
      clr_q  <= clr_d;
      regs_q <= regs_d;
    end
  end

  assign regs_flat = regs_q;

  // R8: a reset sequence leaves every register cleared
  p_clear_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |=> (regs_q == '0));
  // R12: the self-reset bit is never seen set
  p_self_bit_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[0][7]);
  // R6: reserved selects leave the registers untouched
  p_reserved_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clearing && (wr_sel >= SEL_W'(NUM_REGS))) |=> $stable(regs_q));
endmodule

// File: rtl/ctlw_tx.sv
module ctlw_tx
  import ctlw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 frame_evt,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  output logic                 sdo,
  output logic                 sdo_fs
);
  logic [WORD_BITS-1:0] pend_q, pend_d;
  logic                 pvld_q, pvld_d;
  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic [4:0]           cnt_q, cnt_d;
  logic                 sdo_q, sdo_d;
  logic                 fs_q, fs_d;

  always_comb begin
    pend_d = pend_q;
    pvld_d = pvld_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    sdo_d  = sdo_q;
    fs_d   = fs_q;
    if (load) begin
      pend_d = load_word;
      pvld_d = 1'b1;
    end
    if (tick) begin
      if (frame_evt) begin
        fs_d   = 1'b1;
        sdo_d  = 1'b0;
        sh_d   = pvld_q ? pend_q : '0;
        pvld_d = load;
        cnt_d  = 5'(WORD_BITS);
      end else begin
        fs_d = 1'b0;
        if (cnt_q != '0) begin
          sdo_d = sh_q[WORD_BITS-1];
          sh_d  = {sh_q[WORD_BITS-2:0], 1'b0};
          cnt_d = cnt_q - 1'b1;
        end else begin
          sdo_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pvld_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pvld_q <= pvld_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      sdo_q  <= sdo_d;
      fs_q   <= fs_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_fs = fs_q;

  // R9: frame sync lasts one serial clock period
  p_fs_one_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && tick) |=> !fs_q);
  // R10: a queued word is kept until a frame takes it
  p_pending_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pvld_q && !frame_evt) |=> pvld_q);
endmodule

// File: rtl/ctlw_chain.sv
module ctlw_chain
  import ctlw_pkg::*;
#(
  parameter int NUM_REGS   = 5,
  parameter int SCLK_DIV   = 8,
  parameter int FRAME_DIV  = 2048,
  parameter int FIRST_FS   = 280,
  parameter int RST_CYCLES = 4
) (
  input  logic                  mclk,
  input  logic                  rst_n,
  input  logic                  sdi,
  input  logic                  sdi_fs,
  output logic                  sclk,
  output logic                  sdo,
  output logic                  sdo_fs,
  output logic                  data_mode,
  output logic [NUM_REGS*8-1:0] ctl_regs
);
  logic       tick, frame_evt;
  logic       rx_vld;
  ctlw_word_t rx_word;
  ctlw_word_t tx_word;
  logic       wr_en, tx_load, local_hit;
  logic [7:0] rd_data;

  ctlw_timing #(
    .SCLK_DIV (SCLK_DIV),
    .FRAME_DIV(FRAME_DIV),
    .FIRST_FS (FIRST_FS)
  ) u_timing (
    .clk      (mclk),
    .rst_n    (rst_n),
    .tick     (tick),
    .frame_evt(frame_evt),
    .sclk     (sclk)
  );

  ctlw_rx u_rx (
    .clk     (mclk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sdi     (sdi),
    .sdi_fs  (sdi_fs),
    .word_vld(rx_vld),
    .word    (rx_word)
  );

  always_comb begin
    local_hit = (rx_word.dev == 3'd0);
    wr_en     = rx_vld && rx_word.ctl && local_hit && !rx_word.rd;
    tx_load   = rx_vld && rx_word.ctl && (!local_hit || rx_word.rd);
    tx_word   = rx_word;
    if (!local_hit) tx_word.dev  = rx_word.dev - 3'd1;
    else            tx_word.data = rd_data;
  end

  ctlw_regfile #(
    .NUM_REGS  (NUM_REGS),
    .RST_CYCLES(RST_CYCLES),
    .SEL_W     (SEL_BITS)
  ) u_regs (
    .clk      (mclk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (rx_word.sel),
    .wr_data  (rx_word.data),
    .rd_sel   (rx_word.sel),
    .rd_data  (rd_data),
    .regs_flat(ctl_regs)
  );

  ctlw_tx u_tx (
    .clk      (mclk),
    .rst_n    (rst_n),
    .tick     (tick),
    .frame_evt(frame_evt),
    .load     (tx_load),
    .load_word(tx_word),
    .sdo      (sdo),
    .sdo_fs   (sdo_fs)
  );

  assign data_mode = ctl_regs[0];

  // R2: data words never touch the registers
  p_data_word_inert_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    (rx_vld && !rx_word.ctl) |=> $stable(ctl_regs));
  // R3: a forwarded address is never zero-to-seven wrapped
  p_fwd_no_wrap_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (tx_load && !local_hit) |-> (tx_word.dev != 3'd7));
endmodule

// File: tb/sim_ctlw_chain.sv
`timescale 1ns/1ps
module sim_ctlw_chain;
  localparam int NREG  = 5;
  localparam int FRAME = 256;

  logic mclk = 1'b0;
  logic rst_n, sdi, sdi_fs;
  logic sclk, sdo, sdo_fs, data_mode;
  logic [NREG*8-1:0] ctl_regs;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [8];

  always #4 mclk = ~mclk;

  ctlw_chain #(.FRAME_DIV(FRAME)) u0 (
    .mclk(mclk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
    .sclk(sclk), .sdo(sdo), .sdo_fs(sdo_fs),
    .data_mode(data_mode), .ctl_regs(ctl_regs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model_flat();
    return {m[4], m[3], m[2], m[1], m[0]};
  endfunction

  function automatic logic [15:0] cw(input logic ctl, input logic rd,
                                     input int dev, input int sel, input logic [7:0] d);
    return {ctl, rd, 3'(dev), 3'(sel), d};
  endfunction

  task automatic xact(input logic [15:0] w, input logic [15:0] exp, input string req);
    logic [15:0] got;
    do @(posedge sclk); while (sdo_fs !== 1'b1);
    @(negedge sclk); sdi_fs = 1'b1; sdi = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge sclk); sdi_fs = 1'b0; sdi = w[i];
    end
    @(negedge sclk); sdi = 1'b0;
    do @(posedge sclk); while (sdo_fs !== 1'b1);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      @(posedge sclk); got = {got[14:0], sdo};
    end
    chk(req, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, first;
    time t0, t1;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    rst_n = 1'b0; sdi = 1'b0; sdi_fs = 1'b0;
    repeat (3) @(posedge mclk);
    chk("R7 regs in reset", ctl_regs, 0);
    chk("R11 mode in reset", data_mode, 0);
    @(negedge mclk) rst_n = 1'b1;
    n = 0; first = -1;
    while (first < 0 && n < 400) begin
      @(posedge mclk); n++;
      #1;
      if (sdo_fs) first = n;
    end
    chk("R9 first frame sync delay", first, 280);
    chk("R7 regs after release", ctl_regs, 0);

    @(posedge sclk); t0 = $time; @(posedge sclk); t1 = $time;
    chk("R13 sclk period ns", t1 - t0, 64);
    @(negedge sclk); t0 = $time; @(posedge sclk); t1 = $time;
    chk("R13 sclk low first half ns", t1 - t0, 32);
    @(posedge sdo_fs); t0 = $time; @(negedge sdo_fs); t1 = $time;
    chk("R9 frame sync width ns", t1 - t0, 64);
    @(posedge sdo_fs); t1 = $time;
    chk("R9 frame period ns", t1 - t0, FRAME * 8);

    // writes to every select, two patterns (R4, R6, R10)
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 8; s++) begin
        d = 8'(8'h3C ^ (s * 8'h25) ^ (k * 8'hC3));
        if (s == 0) d = d & 8'h7E;
        xact(cw(1, 0, 0, s, d), 16'h0000, "R10 no output after write");
        if (s < NREG) m[s] = d;
        chk(s < NREG ? "R4 register write" : "R6 reserved write ignored",
            ctl_regs, model_flat());
      end
      for (int s = 0; s < 8; s++)
        xact(cw(1, 1, 0, s, 8'h5A), cw(1, 1, 0, s, s < NREG ? m[s] : 8'h00),
             s < NREG ? "R5 readback" : "R6 reserved reads zero");
    end

    // forwarding across every nonzero address (R3)
    for (int dv = 1; dv < 8; dv++) begin
      for (int r = 0; r < 2; r++) begin
        d = 8'(8'hA5 ^ (dv * 8'h11) ^ (r * 8'hFF));
        xact(cw(1, r[0], dv, (dv + r) % 8, d), cw(1, r[0], dv - 1, (dv + r) % 8, d),
             "R3 forward with lowered address");
        chk("R3 regs untouched by forward", ctl_regs, model_flat());
      end
    end

    // bit 15 low in program mode (R2)
    xact(cw(0, 0, 0, 1, 8'hFF), 16'h0000, "R2 data word program mode no output");
    chk("R2 data word program mode regs", ctl_regs, model_flat());
    xact(cw(0, 1, 3, 2, 8'h77), 16'h0000, "R2 data word not forwarded");

    // mixed mode (R11)
    xact(cw(1, 0, 0, 0, 8'h01), 16'h0000, "R11 mode write no output");
    m[0] = 8'h01;
    chk("R11 data_mode set", data_mode, 1);
    xact(cw(0, 0, 0, 2, 8'hEE), 16'h0000, "R2 data word mixed mode no output");
    chk("R2 data word mixed mode regs", ctl_regs, model_flat());
    xact(cw(1, 1, 0, 2, 8'h00), cw(1, 1, 0, 2, m[2]), "R5 readback in mixed mode");
    xact(cw(1, 0, 2, 4, 8'h3D), cw(1, 0, 1, 4, 8'h3D), "R3 forward in mixed mode");

    // self reset (R8, R12)
    xact(cw(1, 0, 0, 0, 8'hFF), 16'h0000, "R8 self reset no output");
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    chk("R8 all regs cleared", ctl_regs, 0);
    chk("R11 mode cleared by self reset", data_mode, 0);
    xact(cw(1, 1, 0, 0, 8'hAA), cw(1, 1, 0, 0, 8'h00), "R12 bit 7 reads zero");
    xact(cw(1, 0, 0, 3, 8'h96), 16'h0000, "R8 writes work after self reset");
    m[3] = 8'h96;
    chk("R8 write after self reset", ctl_regs, model_flat());
    xact(cw(1, 1, 0, 3, 8'h00), cw(1, 1, 0, 3, 8'h96), "R1 R5 final readback");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule